// File: doc/BRIEF.md
# Double-Buffered Divider Programming Port

This block holds the divider settings for a frequency synthesizer loop: a 9-bit main count, a 6-bit reference count and a 5-bit swallow count, plus one byte of enhancement control bits. Settings arrive either over an 8-bit parallel bus, one byte section per write strobe, or over a serial data/clock pair that shifts a full 20-bit word. The mode is chosen by two static pins. The settings land in a primary register. A hop strobe copies the primary register into a secondary register. A level select then chooses which of the two registers drives the counter control outputs. Software can preload the next channel into the primary register while the loop runs from the secondary one, and the select input then switches channels in one step.

All strobes, the serial clock and both data inputs pass through one common synchronizer into the system clock and are edge-detected there. Every register update is therefore synchronous, and parallel data and serial data stay aligned with their strobes.

Top module: `pll_prog_if`

## Requirements
- R1: While `rst` is high at a clock edge, the primary, secondary and enhancement registers clear to zero, so every output reads zero for either select value.
- R2: Primary word layout: bits [8:0] are M, bits [14:9] are R, bits [19:15] are A. In parallel mode (`mode_b`=0, `mode_s`=0), a rising `wr_m1` loads `pdata` into bits [7:0], a rising `wr_m2` loads it into bits [15:8], and a rising `wr_a` loads `pdata[3:0]` into bits [19:16] (`pdata[7:4]` ignored).
- R3: In parallel mode, a rising `wr_hop` copies the whole primary word into the secondary register and leaves the primary word unchanged.
- R4: In parallel mode, `sel_par`=1 drives the outputs from the primary word and `sel_par`=0 drives them from the secondary word. The path from select to output is combinational.
- R5: In parallel mode, a rising `wr_enh` loads `pdata` into the enhancement register, which drives `enh_bits`. In serial mode `wr_enh` never loads it.
- R6: In serial mode (`mode_b`=0, `mode_s`=1), each rising `ser_clk` shifts the primary word left by one bit and takes `ser_dat` into bit 0. Twenty clocks therefore load a word sent most significant bit first.
- R7: In serial mode, a rising edge of either `ser_wr` or `wr_hop` copies the primary word into the secondary register.
- R8: In serial mode, `sel_ser` chooses the source with the same polarity as R4 (1 selects primary, 0 selects secondary), and `sel_par` has no effect.
- R9: In serial mode, serial clock edges are ignored while `wr_enh` or `ser_wr` is high, and the parallel byte strobes are ignored.
- R10: With `mode_b`=1, every strobe and serial clock is ignored, and the outputs show the secondary word.
- R11: A strobe edge takes effect at the third rising clock edge after the strobe rises. The output is still unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b | input | 1 | Mode pin; high selects the unsupported mode in which all writes are ignored |
| mode_s | input | 1 | Mode pin; with mode_b low, 0 selects parallel and 1 selects serial |
| pdata | input | 8 | Parallel data bus |
| wr_m1 | input | 1 | Strobe for primary section 0 (bits 7:0) |
| wr_m2 | input | 1 | Strobe for primary section 1 (bits 15:8) |
| wr_a | input | 1 | Strobe for primary section 2 (bits 19:16) |
| wr_hop | input | 1 | Primary-to-secondary copy strobe |
| wr_enh | input | 1 | Enhancement register strobe |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_wr | input | 1 | Serial copy strobe; its high level blocks shifting |
| sel_par | input | 1 | Source select in parallel mode |
| sel_ser | input | 1 | Source select in serial mode |
| m_word | output | 9 | Main counter control word |
| a_word | output | 5 | Swallow counter control word |
| r_word | output | 6 | Reference counter control word |
| enh_bits | output | 8 | Enhancement control bits |

## Verification
The parallel path is tried with byte values whose bits differ across section boundaries, so a section written to the wrong slice or a dropped upper nibble on the A section shows up in the decoded M, R and A fields. The hop copy is tested by rewriting the primary register after a copy and reading both select settings: this separates a real snapshot from a live alias. Serial loading uses an irregular 20-bit pattern, which exposes bit-order and off-by-one shift errors. Shifting with the blocking strobes held high, strobes in the wrong mode, and the unsupported mode each confirm that the register that could have changed is untouched. The enhancement strobe is sampled one cycle before and one cycle after the expected edge to pin down the synchronizer latency.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

    localparam int WORD_W   = 20;
    localparam int M_W      = 9;
    localparam int R_W      = 6;
    localparam int A_W      = 5;
    localparam int BYTE_W   = 8;
    localparam int NUM_SECT = (WORD_W + BYTE_W - 1) / BYTE_W;

    // strobe lane indices inside the synchronizer
    localparam int STB_M1  = 0;
    localparam int STB_M2  = 1;
    localparam int STB_A   = 2;
    localparam int STB_HOP = 3;
    localparam int STB_ENH = 4;
    localparam int STB_SWR = 5;
    localparam int STB_SCK = 6;
    localparam int NUM_STB = 7;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_OFF = 2'd2
    } if_mode_e;

    // field layout of the 20-bit divider word: A on top, R in the middle, M at the bottom
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
    } div_word_t;

    function automatic if_mode_e decode_mode(input logic mb, input logic ms);
        if (mb)
            return MODE_OFF;
        return ms ? MODE_SER : MODE_PAR;
    endfunction

endpackage

// File: rtl/pll_strobe_sync.sv
module pll_strobe_sync #(
    parameter int N_STB  = 7,
    parameter int N_DAT  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_STB-1:0] stb_in,
    input  logic [N_DAT-1:0] dat_in,
    output logic [N_STB-1:0] stb_lvl,
    output logic [N_STB-1:0] stb_rise,
    output logic [N_DAT-1:0] dat_out
);
    localparam int W = N_STB + N_DAT;

    logic [STAGES-1:0][W-1:0] pipe;
    logic [N_STB-1:0]         stb_last;

    // strobes and data share one pipeline so they stay aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe     <= '0;
            stb_last <= '0;
        end else begin
            pipe[0] <= {stb_in, dat_in};
            for (int s = 1; s < STAGES; s++)
                pipe[s] <= pipe[s-1];
            stb_last <= stb_lvl;
        end
    end

    assign {stb_lvl, dat_out} = pipe[STAGES-1];
    assign stb_rise           = stb_lvl & ~stb_last;

endmodule

// File: rtl/pll_load_regs.sv
module pll_load_regs
    import pll_prog_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  if_mode_e            mode,
    input  logic [NUM_STB-1:0]  stb_lvl,
    input  logic [NUM_STB-1:0]  stb_rise,
    input  logic [BYTE_W-1:0]   pd,
    input  logic                sd,
    output div_word_t           prim_q,
    output div_word_t           sec_q,
    output logic [BYTE_W-1:0]   enh_q
);
    logic                  par_m, ser_m;
    logic [NUM_SECT-1:0]   sect_evt;
    logic                  hop_evt, shift_evt, enh_evt, shift_hold;
    logic [WORD_W-1:0]     prim_nxt;

    assign par_m = (mode == MODE_PAR);
    assign ser_m = (mode == MODE_SER);

    assign sect_evt[0] = par_m & stb_rise[STB_M1];
    assign sect_evt[1] = par_m & stb_rise[STB_M2];
    assign sect_evt[2] = par_m & stb_rise[STB_A];

    assign shift_hold = stb_lvl[STB_ENH] | stb_lvl[STB_SWR];
    assign shift_evt  = ser_m & stb_rise[STB_SCK] & ~shift_hold;
    assign enh_evt    = par_m & stb_rise[STB_ENH];
    assign hop_evt    = (par_m & stb_rise[STB_HOP]) |
                        (ser_m & (stb_rise[STB_HOP] | stb_rise[STB_SWR]));

    always_comb begin
        prim_nxt = prim_q;
        for (int b = 0; b < WORD_W; b++)
            if (sect_evt[b / BYTE_W])
                prim_nxt[b] = pd[b % BYTE_W];
        if (shift_evt)
            prim_nxt = {prim_q[WORD_W-2:0], sd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            sec_q  <= '0;
            enh_q  <= '0;
        end else begin
            prim_q <= prim_nxt;
            if (hop_evt)
                sec_q <= prim_q;
            if (enh_evt)
                enh_q <= pd;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (prim_q == '0) && (sec_q == '0) && (enh_q == '0));

    p_hop_copy_r3: assert property (@(posedge clk) disable iff (rst)
        hop_evt |=> sec_q == $past(prim_q));

    p_sec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !hop_evt |=> $stable(sec_q));

    p_enh_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !enh_evt |=> $stable(enh_q));

    p_shift_r6: assert property (@(posedge clk) disable iff (rst)
        shift_evt |=> prim_q[WORD_W-1:1] == $past(prim_q[WORD_W-2:0]));

    p_serial_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (ser_m && shift_hold) |=> $stable(prim_q));

    p_off_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> $stable(prim_q) && $stable(sec_q) && $stable(enh_q));

endmodule

// File: rtl/pll_word_mux.sv
module pll_word_mux
    import pll_prog_pkg::*;
(
    input  if_mode_e  mode,
    input  logic      sel_par,
    input  logic      sel_ser,
    input  div_word_t prim,
    input  div_word_t sec,
    output div_word_t word
);
    logic use_prim;

    always_comb begin
        unique case (mode)
            MODE_PAR: use_prim = sel_par;
            MODE_SER: use_prim = sel_ser;
            default:  use_prim = 1'b0;
        endcase
    end

    assign word = use_prim ? prim : sec;

endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
    import pll_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_b,
    input  logic         mode_s,
    input  logic [7:0]   pdata,
    input  logic         wr_m1,
    input  logic         wr_m2,
    input  logic         wr_a,
    input  logic         wr_hop,
    input  logic         wr_enh,
    input  logic         ser_dat,
    input  logic         ser_clk,
    input  logic         ser_wr,
    input  logic         sel_par,
    input  logic         sel_ser,
    output logic [8:0]   m_word,
    output logic [4:0]   a_word,
    output logic [5:0]   r_word,
    output logic [7:0]   enh_bits
);
    localparam int N_DAT = BYTE_W + 1;

    if_mode_e            mode;
    logic [NUM_STB-1:0]  stb_raw, stb_lvl, stb_rise;
    logic [N_DAT-1:0]    dat_s;
    div_word_t           prim, sec, word;

    assign mode = decode_mode(mode_b, mode_s);

    always_comb begin
        stb_raw          = '0;
        stb_raw[STB_M1]  = wr_m1;
        stb_raw[STB_M2]  = wr_m2;
        stb_raw[STB_A]   = wr_a;
        stb_raw[STB_HOP] = wr_hop;
        stb_raw[STB_ENH] = wr_enh;
        stb_raw[STB_SWR] = ser_wr;
        stb_raw[STB_SCK] = ser_clk;
    end

    pll_strobe_sync #(
        .N_STB  (NUM_STB),
        .N_DAT  (N_DAT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .stb_in   (stb_raw),
        .dat_in   ({ser_dat, pdata}),
        .stb_lvl  (stb_lvl),
        .stb_rise (stb_rise),
        .dat_out  (dat_s)
    );

    pll_load_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .stb_lvl  (stb_lvl),
        .stb_rise (stb_rise),
        .pd       (dat_s[BYTE_W-1:0]),
        .sd       (dat_s[BYTE_W]),
        .prim_q   (prim),
        .sec_q    (sec),
        .enh_q    (enh_bits)
    );

    pll_word_mux u_mux (
        .mode    (mode),
        .sel_par (sel_par),
        .sel_ser (sel_ser),
        .prim    (prim),
        .sec     (sec),
        .word    (word)
    );

    assign m_word = word.m;
    assign a_word = word.a;
    assign r_word = word.r;

    p_route_par_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_b && !mode_s) |-> ({a_word, r_word, m_word} == (sel_par ? prim : sec)));

    p_route_ser_r8: assert property (@(posedge clk) disable iff (rst)
        (!mode_b && mode_s) |-> ({a_word, r_word, m_word} == (sel_ser ? prim : sec)));

    p_route_off_r10: assert property (@(posedge clk) disable iff (rst)
        mode_b |-> ({a_word, r_word, m_word} == sec));

endmodule

// File: tb/pll_prog_if_tb.sv
module pll_prog_if_tb;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_b = 1'b0, mode_s = 1'b0;
    logic [7:0] pdata = '0;
    logic       wr_m1 = 0, wr_m2 = 0, wr_a = 0, wr_hop = 0, wr_enh = 0;
    logic       ser_dat = 0, ser_clk = 0, ser_wr = 0;
    logic       sel_par = 0, sel_ser = 0;
    logic [8:0] m_word;
    logic [4:0] a_word;
    logic [5:0] r_word;
    logic [7:0] enh_bits;

    int errors = 0;
    int checks = 0;
    logic [19:0] exp_prim = '0, exp_sec = '0;

    always #(CLK_NS/2) clk = ~clk;

    pll_prog_if u_dut (
        .clk(clk), .rst(rst), .mode_b(mode_b), .mode_s(mode_s), .pdata(pdata),
        .wr_m1(wr_m1), .wr_m2(wr_m2), .wr_a(wr_a), .wr_hop(wr_hop), .wr_enh(wr_enh),
        .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_wr(ser_wr),
        .sel_par(sel_par), .sel_ser(sel_ser),
        .m_word(m_word), .a_word(a_word), .r_word(r_word), .enh_bits(enh_bits)
    );

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_word(input string tag, input logic [19:0] exp);
        logic [19:0] act;
        #1;
        act = {a_word, r_word, m_word};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: word actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic chk_enh(input string tag, input logic [7:0] exp);
        checks++;
        if (enh_bits !== exp) begin
            errors++;
            $display("FAIL %s: enh actual=%02h expected=%02h", tag, enh_bits, exp);
        end
    endtask

    // pulse a parallel strobe: 0=m1 1=m2 2=a 3=hop 4=enh 5=ser_wr
    task automatic strobe(input int which, input logic [7:0] d);
        pdata = d;
        case (which)
            0: wr_m1 = 1; 1: wr_m2 = 1; 2: wr_a = 1;
            3: wr_hop = 1; 4: wr_enh = 1; default: ser_wr = 1;
        endcase
        idle(4);
        {wr_m1, wr_m2, wr_a, wr_hop, wr_enh, ser_wr} = '0;
        idle(4);
    endtask

    task automatic ser_bit(input logic b);
        ser_dat = b;
        ser_clk = 0;
        idle(3);
        ser_clk = 1;
        idle(3);
        ser_clk = 0;
    endtask

    task automatic t_reset();
        sel_par = 1; chk_word("R1 reset primary", 20'h0);
        sel_par = 0; chk_word("R1 reset secondary", 20'h0);
        chk_enh("R1 reset enh", 8'h00);
    endtask

    task automatic t_parallel();
        mode_b = 0; mode_s = 0;
        strobe(0, 8'hA5);
        strobe(1, 8'h3C);
        strobe(2, 8'hF7);               // upper nibble dropped
        exp_prim = {4'h7, 8'h3C, 8'hA5};
        sel_par = 1; chk_word("R2 byte sections", exp_prim);
        checks++;
        if (m_word !== 9'h0A5 || r_word !== 6'h1E || a_word !== 5'h0E) begin
            errors++;
            $display("FAIL R2 fields: actual m=%h r=%h a=%h expected m=0a5 r=1e a=0e",
                     m_word, r_word, a_word);
        end
        sel_par = 0; chk_word("R4 select low shows secondary", exp_sec);
    endtask

    task automatic t_hop();
        strobe(3, 8'h00);
        exp_sec = exp_prim;
        sel_par = 0; chk_word("R3 hop copies", exp_sec);
        sel_par = 1; chk_word("R3 primary kept after hop", exp_prim);
        strobe(0, 8'h5A);
        exp_prim[7:0] = 8'h5A;
        sel_par = 1; chk_word("R4 select high new primary", exp_prim);
        sel_par = 0; chk_word("R4 secondary is a snapshot", exp_sec);
    endtask

    task automatic t_enh();
        pdata = 8'hC3;
        wr_enh = 1;
        idle(2);
        chk_enh("R11 not yet after two edges", 8'h00);
        idle(1);
        chk_enh("R11 R5 loaded at third edge", 8'hC3);
        wr_enh = 0;
        idle(4);
    endtask

    task automatic t_serial();
        logic [19:0] pat = 20'hB1E4D;
        mode_s = 1;
        for (int i = 19; i >= 0; i--) ser_bit(pat[i]);
        idle(4);
        exp_prim = pat;
        sel_ser = 1; sel_par = 0; chk_word("R6 serial word msb first", exp_prim);
        sel_ser = 0; sel_par = 1; chk_word("R8 sel_ser low, sel_par ignored", exp_sec);
        strobe(5, 8'h00);
        exp_sec = exp_prim;
        sel_ser = 0; chk_word("R7 ser_wr copies", exp_sec);
        ser_bit(1'b0); idle(4);
        exp_prim = {exp_prim[18:0], 1'b0};
        sel_ser = 1; chk_word("R6 single shift", exp_prim);
        strobe(3, 8'h00);
        exp_sec = exp_prim;
        sel_ser = 0; chk_word("R7 hop copies in serial mode", exp_sec);
    endtask

    task automatic t_serial_gate();
        wr_enh = 1; pdata = 8'h99;
        idle(3);
        ser_bit(1); ser_bit(1); ser_bit(0);
        wr_enh = 0; idle(4);
        sel_ser = 1; chk_word("R9 shift blocked by enh strobe", exp_prim);
        chk_enh("R5 enh not loaded in serial mode", 8'hC3);
        ser_wr = 1; idle(3);
        ser_bit(1); ser_bit(0);
        ser_wr = 0; idle(4);
        exp_sec = exp_prim;       // ser_wr rise copied the unchanged primary
        sel_ser = 1; chk_word("R9 shift blocked by ser_wr", exp_prim);
        strobe(0, 8'hFF);
        sel_ser = 1; chk_word("R9 byte strobe ignored in serial", exp_prim);
    endtask

    task automatic t_off();
        mode_b = 1; mode_s = 0;
        sel_par = 1; sel_ser = 1;
        chk_word("R10 output shows secondary", exp_sec);
        strobe(0, 8'h11); strobe(2, 8'h0F); strobe(4, 8'h66); strobe(3, 8'h00);
        ser_bit(1);
        idle(4);
        chk_word("R10 secondary untouched", exp_sec);
        chk_enh("R10 enh untouched", 8'hC3);
        mode_b = 0; idle(1);
        sel_par = 1; chk_word("R10 primary untouched", exp_prim);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        t_reset();
        t_parallel();
        t_hop();
        t_enh();
        t_serial();
        t_serial_gate();
        t_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule